// File: doc/BRIEF.md
# Segment-Relative Linear Address Generator

This block converts a segment-relative memory access into a 32-bit linear address and decides whether the access is legal. Each request carries the hidden state of the chosen segment register (base, limit and a usable flag), an effective offset, an address-size mode and an access width of one, two or four bytes. The block forms the offset for the current address size, adds the segment base, and checks that every byte of the access falls within the segment limit.

The checks use only the hidden limit and the usable flag. The block does not know which processor mode is active. When a segment keeps a large limit after a mode change, accesses through it may go past 64 KiB even though the offset is still formed in 16 bits. The result appears one clock after the request, as a valid pulse with a linear address and a fault flag.

Top module: `sag_addr_gen`

## Requirements
- R1: When `addr32` is 0, only bits 15:0 of `offset` are used. Bits 31:16 have no effect on the linear address or on the limit check. For example, an offset of 0x15000 behaves as offset 0x5000.
- R2: The linear address is `seg_base` plus the effective offset, modulo 2^32. For example, base 0xFFFFFFF0 plus offset 0x20 gives 0x00000010.
- R3: The limit holds the segment length minus one. An access faults when its last byte (effective offset + bytes − 1) is above `seg_limit`. The sum is formed without loss above 32 bits. A 2-byte access at offset 0xFFFF with limit 0xFFFF therefore faults, and it does not wrap to offset 0.
- R4: An access whose last byte is at or below the limit does not fault. This includes a 1-byte access exactly at the limit and a 4-byte access ending exactly at the limit.
- R5: An access with `seg_usable` = 0 always faults, whatever the offset and the limit.
- R6: With limit 0xFFFFFFFF and `addr32` = 0, no usable 1-, 2- or 4-byte access faults. For example, a 2-byte access at 0xFFFF is legal.
- R7: `out_valid` rises exactly one cycle after a cycle with `in_valid` = 1, and it is 0 one cycle after a cycle with `in_valid` = 0. Back-to-back requests produce back-to-back results in order.
- R8: The access-width code in `acc_width` is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. Code 3 is reserved and always faults.
- R9: After reset, `out_valid`, `fault` and `lin_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| seg_base | input | 32 | Hidden segment base |
| seg_limit | input | 32 | Hidden segment limit (length minus one) |
| seg_usable | input | 1 | 0 when the segment holds a null load |
| offset | input | 32 | Effective offset |
| addr32 | input | 1 | 1 selects 32-bit offsets, 0 selects 16-bit offsets |
| acc_width | input | 2 | Width code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| out_valid | output | 1 | Result valid, one cycle after the request |
| lin_addr | output | 32 | Linear address of the first byte |
| fault | output | 1 | Limit, usability or width violation |

## Verification
The bench aims at the edges of the limit comparison: the last legal byte, one byte past it, and a word that straddles 0xFFFF under a 64 KiB limit and under a 4 GiB limit. A design that checked only the first byte would let the straddling word through. A design that wrapped the offset would not fault at all.

A 32-bit offset near 0xFFFFFFFF under the full limit exposes a last-byte sum kept in only 32 bits: the carry would be lost and the access would pass. Offsets with their upper half set in 16-bit mode catch truncation applied after the add rather than before it. Random traffic, back to back and with gaps, catches results that are late, duplicated or out of order.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned SHORT_W = 16;

  typedef enum logic [1:0] {
    ACC_B1  = 2'd0,
    ACC_B2  = 2'd1,
    ACC_B4  = 2'd2,
    ACC_RSV = 2'd3
  } acc_code_e;

  // Number of bytes for a width code; 0 marks the reserved code.
  function automatic logic [2:0] sag_nbytes(input logic [1:0] code);
    case (code)
      ACC_B1:  sag_nbytes = 3'd1;
      ACC_B2:  sag_nbytes = 3'd2;
      ACC_B4:  sag_nbytes = 3'd4;
      default: sag_nbytes = 3'd0;
    endcase
  endfunction

  // Offset as seen by the segment unit for the given address size.
  function automatic logic [ADDR_W-1:0] sag_trunc(input logic [ADDR_W-1:0] off,
                                                 input logic wide);
    sag_trunc = wide ? off : {{(ADDR_W-SHORT_W){1'b0}}, off[SHORT_W-1:0]};
  endfunction

  // Offset of the final byte, one bit wider so no carry is lost.
  function automatic logic [ADDR_W:0] sag_last(input logic [ADDR_W-1:0] off,
                                              input logic [2:0] nb);
    logic [ADDR_W:0] ext;
    ext = {1'b0, off};
    if (nb == 3'd0) sag_last = ext;
    else sag_last = ext + (ADDR_W+1)'(nb) - (ADDR_W+1)'(1);
  endfunction
endpackage

// File: rtl/sag_offset_unit.sv
module sag_offset_unit
  import sag_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] raw_off,
  input  logic          wide,
  output logic [AW-1:0] eff_off
);
  always_comb eff_off = sag_trunc(raw_off, wide);
endmodule

// File: rtl/sag_limit_check.sv
module sag_limit_check
  import sag_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] eff_off,
  input  logic [1:0]    width_code,
  input  logic [AW-1:0] limit,
  input  logic          usable,
  output logic          width_bad,
  output logic          last_carry,
  output logic          over_limit,
  output logic          fault
);
  logic [2:0]  nbytes;
  logic [AW:0] last_off;

  always_comb begin
    nbytes     = sag_nbytes(width_code);
    last_off   = sag_last(eff_off, nbytes);
    width_bad  = (nbytes == 3'd0);
    last_carry = last_off[AW];
    over_limit = last_carry || (last_off[AW-1:0] > limit);
    fault      = !usable || width_bad || over_limit;
  end
endmodule

// File: rtl/sag_linear_add.sv
module sag_linear_add #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] eff_off,
  output logic [AW-1:0] lin
);
  always_comb lin = base + eff_off;
endmodule

// File: rtl/sag_addr_gen.sv
module sag_addr_gen
  import sag_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] seg_base,
  input  logic [AW-1:0] seg_limit,
  input  logic          seg_usable,
  input  logic [AW-1:0] offset,
  input  logic          addr32,
  input  logic [1:0]    acc_width,
  output logic          out_valid,
  output logic [AW-1:0] lin_addr,
  output logic          fault
);
  logic [AW-1:0] eff_off;
  logic [AW-1:0] lin_next;
  logic          width_bad;
  logic          last_carry;
  logic          over_limit;
  logic          fault_next;

  sag_offset_unit #(.AW(AW)) u_off (
    .raw_off (offset),
    .wide    (addr32),
    .eff_off (eff_off)
  );

  sag_linear_add #(.AW(AW)) u_add (
    .base    (seg_base),
    .eff_off (eff_off),
    .lin     (lin_next)
  );

  sag_limit_check #(.AW(AW)) u_lim (
    .eff_off    (eff_off),
    .width_code (acc_width),
    .limit      (seg_limit),
    .usable     (seg_usable),
    .width_bad  (width_bad),
    .last_carry (last_carry),
    .over_limit (over_limit),
    .fault      (fault_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      lin_addr  <= '0;
      fault     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        lin_addr <= lin_next;
        fault    <= fault_next;
      end
    end
  end
endmodule

// File: rtl/sag_addr_gen_chk.sv
module sag_addr_gen_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [AW-1:0] seg_base,
  input logic [AW-1:0] seg_limit,
  input logic          seg_usable,
  input logic [AW-1:0] offset,
  input logic          addr32,
  input logic [1:0]    acc_width,
  input logic          out_valid,
  input logic [AW-1:0] lin_addr,
  input logic          fault,
  input logic          last_carry
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R7
  AST_SHORT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !addr32) |=>
      (lin_addr - $past(seg_base)) == {{(AW-16){1'b0}}, $past(offset[15:0])}); // R1
  AST_UNUSABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !seg_usable) |=> fault); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && last_carry) |=> fault); // R3
  AST_RESERVED_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_width == 2'd3) |=> fault); // R8
  AST_BYTE_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && seg_usable && addr32 && acc_width == 2'd0 && offset <= seg_limit)
      |=> !fault); // R4
  AST_FULL_LIMIT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && seg_usable && !addr32 && acc_width != 2'd3 && (&seg_limit))
      |=> !fault); // R6
endmodule

bind sag_addr_gen sag_addr_gen_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .seg_base   (seg_base),
  .seg_limit  (seg_limit),
  .seg_usable (seg_usable),
  .offset     (offset),
  .addr32     (addr32),
  .acc_width  (acc_width),
  .out_valid  (out_valid),
  .lin_addr   (lin_addr),
  .fault      (fault),
  .last_carry (last_carry)
);

// File: tb/sim_sag_addr_gen.sv
`timescale 1ns/1ps
module sim_sag_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] seg_base = '0;
  logic [31:0] seg_limit = '0;
  logic        seg_usable = 1'b0;
  logic [31:0] offset = '0;
  logic        addr32 = 1'b0;
  logic [1:0]  acc_width = '0;
  logic        out_valid;
  logic [31:0] lin_addr;
  logic        fault;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  typedef struct {
    logic [31:0] addr;
    logic        flt;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  sag_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .seg_base(seg_base),
    .seg_limit(seg_limit), .seg_usable(seg_usable), .offset(offset),
    .addr32(addr32), .acc_width(acc_width), .out_valid(out_valid),
    .lin_addr(lin_addr), .fault(fault)
  );

  function automatic exp_t model(input logic [31:0] b, input logic [31:0] lim,
                                 input logic u, input logic [31:0] o,
                                 input logic w32, input logic [1:0] wc,
                                 input string tag);
    exp_t e;
    longint unsigned off, n, last;
    off = w32 ? longint'(o) : longint'(o & 32'h0000FFFF);
    n = (wc == 2'd0) ? 1 : (wc == 2'd1) ? 2 : (wc == 2'd2) ? 4 : 0;
    last = off + n - 1;
    e.addr = 32'(longint'(b) + off);
    e.flt = !u || (n == 0) || (last > longint'(lim));
    e.tag = tag;
    return e;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] b, input logic [31:0] lim, input logic u,
                       input logic [31:0] o, input logic w32, input logic [1:0] wc,
                       input string tag);
    @(negedge clk);
    in_valid = 1'b1; seg_base = b; seg_limit = lim; seg_usable = u;
    offset = o; addr32 = w32; acc_width = wc;
    sb.push_back(model(b, lim, u, o, w32, wc, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      offset = 32'hDEAD_BEEF;
    end
  endtask

  // Monitor: samples 5 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (mon_on) begin
        if (sb.size() != 0) begin
          exp_t e;
          e = sb.pop_front();
          chk({e.tag, " valid"}, 64'(out_valid), 64'd1);
          chk({e.tag, " addr"}, 64'(lin_addr), 64'(e.addr));
          chk({e.tag, " fault"}, 64'(fault), 64'(e.flt));
        end else if (out_valid !== 1'b0) begin
          chk("R7 spurious valid", 64'(out_valid), 64'd0);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R9 reset valid", 64'(out_valid), 64'd0);
    chk("R9 reset fault", 64'(fault), 64'd0);
    chk("R9 reset addr", 64'(lin_addr), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;

    drive(32'h0001_0000, 32'h0000_FFFF, 1, 32'h0001_5000, 0, 2'd0, "R1 truncate");
    drive(32'h0000_0100, 32'h0000_FFFF, 1, 32'hABCD_FFFF, 0, 2'd0, "R1 upper ignored");
    drive(32'hFFFF_FFF0, 32'hFFFF_FFFF, 1, 32'h0000_0020, 1, 2'd0, "R2 wrap");
    drive(32'h1234_0000, 32'h0000_FFFF, 1, 32'h0000_FFFF, 0, 2'd1, "R3 word past limit");
    drive(32'h0000_0000, 32'h0000_1000, 1, 32'h0000_0FFF, 1, 2'd2, "R3 dword over");
    drive(32'h0000_0000, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFF, 1, 2'd1, "R3 carry");
    drive(32'h0000_0000, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFD, 1, 2'd2, "R3 carry dword");
    idle(1);
    drive(32'h0000_0000, 32'h0000_1000, 1, 32'h0000_1000, 1, 2'd0, "R4 byte at limit");
    drive(32'h0000_0000, 32'h0000_1000, 1, 32'h0000_0FFD, 1, 2'd2, "R4 dword ends at limit");
    drive(32'h0000_0000, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFC, 1, 2'd2, "R4 top dword");
    drive(32'h0000_0000, 32'hFFFF_FFFF, 0, 32'h0000_0010, 1, 2'd0, "R5 unusable");
    drive(32'h0000_0000, 32'h0000_FFFF, 0, 32'h0000_0000, 0, 2'd0, "R5 unusable zero");
    drive(32'h0000_0000, 32'hFFFF_FFFF, 1, 32'h0000_FFFF, 0, 2'd1, "R6 big limit word");
    drive(32'h000B_8000, 32'hFFFF_FFFF, 1, 32'h0000_FFFE, 0, 2'd2, "R6 big limit dword");
    drive(32'h0000_0000, 32'hFFFF_FFFF, 1, 32'h0000_0000, 1, 2'd3, "R8 reserved width");
    idle(3);
    drive(32'h0000_2000, 32'h0000_00FF, 1, 32'h0000_0010, 1, 2'd1, "R7 after gap");
    idle(2);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] b, lim, o;
      b = $urandom;
      lim = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : ($urandom & 32'h0001_FFFF);
      o = ($urandom_range(0, 1) == 0) ? (lim - 32'($urandom_range(0, 4))) : $urandom;
      drive(b, lim, ($urandom_range(0, 7) != 0), o, 1'($urandom), 2'($urandom),
            "R7 random stream");
      if ($urandom_range(0, 4) == 0) idle(1);
    end
    idle(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule